// File: doc/BRIEF.md
# Anti-Shock Buffer Status Flag Controller

This block holds the status flags of an anti-shock audio buffer kept in DRAM. It watches the buffer fill level, the subcode frame pulses, DRAM write activity, shock detection and the hold/shock mode. It packs the result into an eight-bit status word, which a microcontroller reads over a three-wire serial link made of a load strobe, a serial clock and a data line. The same flags drive a write-resume enable that tells the DRAM side whether refilling may go on after the buffer has drained.

The two top bits of the word report the coarse fill level. A configuration input selects a small or a large buffer: with the small one, the fill-level field spans about 0.78 s of audio, and with the large one about 3 s. Of the six event flags, four are sticky and clear only once the microcontroller has clocked out a full byte that showed them as set. The empty flag follows the write-resume handshake, and the fill flag follows write activity. A frame the microcontroller failed to collect shows up as a framing error, and the new-frame flag stays set when that happens.

The serial inputs are asynchronous to the system clock. They pass through a synchronizer and an edge detector, so the link runs at a fraction of the system clock rate.

Top module: `asb_status_ctrl`

## Requirements
- R1: After reset, `status_word` is 0, `ser_data` is 0 and `wr_resume` is 1.
- R2: Bits 7:6 of the word report the fill level. With `cfg_large`=1 they are `fill_lvl[5:4]`. With `cfg_large`=0 they are `fill_lvl[3:2]`, saturating to 2'b11 when the level exceeds 15 (default widths: 6-bit level, 4-bit small range).
- R3: The full flag (bit 3) sets while the level is at or above the full mark: 15 with `cfg_large`=0, 63 with `cfg_large`=1.
- R4: A `sub_sync` pulse sets the new-frame flag (bit 4).
- R5: A `sub_sync` pulse that arrives while bit 4 is still set also sets the framing error flag (bit 5), and bit 4 stays set.
- R6: Bit 5 sets in any cycle where exactly one of `dec_frame` and `int_frame` is high. Coinciding pulses leave it clear.
- R7: The empty flag (bit 2) sets when the level falls from non-zero to zero while `hold_mode`=1. It clears on `dram_wr`, `cmd_pfb` or `cmd_flush`. A drain to zero with `hold_mode`=0 leaves it clear.
- R8: `wr_resume` is 0 exactly when the empty flag and `cmd_echo` are both 1. While `cmd_echo`=1, only `cmd_pfb` or `cmd_flush` can restore it.
- R9: The fill flag (bit 0) sets on `dram_wr`, `cmd_pfb` or `cmd_flush`. It clears when the full flag or the shock flag (bit 1, set by `shock`) goes from 0 to 1, and that clear wins over a set in the same cycle.
- R10: A rising edge on `ser_load` captures the word and puts bit 7 on `ser_data`. Each rising edge of `ser_clk` then presents the next lower bit, most significant bit first.
- R11: On the eighth `ser_clk` rise after a load, bits 5, 4, 3 and 1 are cleared if they were 1 in the captured word. Flags that set after the capture remain set.
- R12: When a flag's set condition and its read-clear fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_large | input | 1 | Selects the large buffer size |
| fill_lvl | input | 6 | Current buffer fill level |
| sub_sync | input | 1 | Absolute subcode sync recovered |
| dec_frame | input | 1 | Decoder new-frame pulse |
| int_frame | input | 1 | Internally generated new-frame pulse |
| dram_wr | input | 1 | DRAM write taking place |
| shock | input | 1 | Shock detected |
| hold_mode | input | 1 | Hold or shock mode active |
| cmd_pfb | input | 1 | Play-from-buffer command |
| cmd_flush | input | 1 | Flush command |
| cmd_echo | input | 1 | Echo command bit |
| ser_clk | input | 1 | Serial read clock (asynchronous) |
| ser_load | input | 1 | Serial load strobe (asynchronous) |
| status_word | output | 8 | Live status word |
| ser_data | output | 1 | Serial status data, MSB first |
| wr_resume | output | 1 | DRAM writing may resume |

## Verification
The hardest situation to reach is one where a flag's set condition lines up with the read-clear that ends a serial transfer. The clear comes several system clocks after the eighth serial clock edge, because the link is synchronized. The stimulus therefore holds the set source (`sub_sync`, `shock`, a full level) steady across the whole transfer, so the coincidence is certain without any need to predict the exact cycle. For the snapshot rule, the stimulus pulses `shock` between the load and the last shift. A fill-level sweep covers every level in both buffer configurations and reads the word back after each step.

// File: rtl/asb_pkg.sv
package asb_pkg;
  localparam int STAT_W   = 8;
  localparam int FLAG_W   = 6;
  localparam int B_FILL   = 0;
  localparam int B_SHOCK  = 1;
  localparam int B_EMPTY  = 2;
  localparam int B_FULL   = 3;
  localparam int B_NEWFRM = 4;
  localparam int B_FRMERR = 5;
  // flags cleared by a completed serial read
  localparam logic [FLAG_W-1:0] RD_CLR_MASK = 6'b111010;
endpackage

// File: rtl/asb_sync_edge.sv
module asb_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], din};
  end

  always_ff @(posedge clk) begin
    if (rst) rise <= 1'b0;
    else     rise <= chain[STAGES-1] & ~chain[STAGES];
  end
endmodule

// File: rtl/asb_serial_out.sv
module asb_serial_out #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_data,
  output logic [WIDTH-1:0] snap,
  output logic             done
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [WIDTH-1:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      snap   <= '0;
      cnt    <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        shreg  <= par_in;
        snap   <= par_in;
        cnt    <= '0;
        active <= 1'b1;
      end else if (shift && active) begin
        shreg <= {shreg[WIDTH-2:0], 1'b0};
        cnt   <= cnt + 1'b1;
        if (cnt == LAST) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign ser_data = shreg[WIDTH-1];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(WIDTH)) else $error("shift count overrun"); // R10
  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (rst)
    load |=> (ser_data == snap[WIDTH-1])) else $error("load msb"); // R10
endmodule

// File: rtl/asb_flag_bank.sv
module asb_flag_bank
  import asb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_evt,
  input  logic              dec_frame,
  input  logic              int_frame,
  input  logic              full_now,
  input  logic              drain_evt,
  input  logic              dram_wr,
  input  logic              shock,
  input  logic              cmd_pfb,
  input  logic              cmd_flush,
  input  logic [FLAG_W-1:0] rd_clr,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] set_v;
  logic [FLAG_W-1:0] clr_v;
  logic              refill;

  always_comb begin
    refill = dram_wr | cmd_pfb | cmd_flush;
    set_v = '0;
    clr_v = rd_clr;
    set_v[B_NEWFRM] = sync_evt;
    set_v[B_FRMERR] = (sync_evt & flags[B_NEWFRM]) | (dec_frame ^ int_frame);
    set_v[B_FULL]   = full_now;
    set_v[B_SHOCK]  = shock;
    set_v[B_EMPTY]  = drain_evt;
    clr_v[B_EMPTY]  = rd_clr[B_EMPTY] | refill;
    set_v[B_FILL]   = refill;
    clr_v[B_FILL]   = rd_clr[B_FILL] | (full_now & ~flags[B_FULL])
                      | (shock & ~flags[B_SHOCK]);
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    if (i == B_FILL) begin : g_clr_wins
      always_ff @(posedge clk) begin
        if (rst) flags[i] <= 1'b0;
        else     flags[i] <= ~clr_v[i] & (set_v[i] | flags[i]);
      end
    end else begin : g_set_wins
      always_ff @(posedge clk) begin
        if (rst) flags[i] <= 1'b0;
        else     flags[i] <= set_v[i] | (flags[i] & ~clr_v[i]);
      end
    end
  end

  AST_NEWFRM_SET: assert property (@(posedge clk) disable iff (rst)
    sync_evt |=> flags[B_NEWFRM]) else $error("new frame"); // R4
  AST_FRAME_MISSED: assert property (@(posedge clk) disable iff (rst)
    (sync_evt && flags[B_NEWFRM]) |=> (flags[B_FRMERR] && flags[B_NEWFRM]))
    else $error("missed frame"); // R5
  AST_FRAME_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    (dec_frame != int_frame) |=> flags[B_FRMERR]) else $error("mismatch"); // R6
  AST_FILL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (shock && !flags[B_SHOCK]) |=> !flags[B_FILL]) else $error("fill clr"); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (full_now && rd_clr[B_FULL]) |=> flags[B_FULL]) else $error("set wins"); // R12
endmodule

// File: rtl/asb_status_ctrl.sv
module asb_status_ctrl
  import asb_pkg::*;
#(
  parameter int LEVEL_W     = 6,
  parameter int SMALL_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_large,
  input  logic [LEVEL_W-1:0] fill_lvl,
  input  logic               sub_sync,
  input  logic               dec_frame,
  input  logic               int_frame,
  input  logic               dram_wr,
  input  logic               shock,
  input  logic               hold_mode,
  input  logic               cmd_pfb,
  input  logic               cmd_flush,
  input  logic               cmd_echo,
  input  logic               ser_clk,
  input  logic               ser_load,
  output logic [STAT_W-1:0]  status_word,
  output logic               ser_data,
  output logic               wr_resume
);
  localparam logic [LEVEL_W-1:0] FULL_SMALL = LEVEL_W'((1 << SMALL_W) - 1);
  localparam logic [LEVEL_W-1:0] FULL_LARGE = {LEVEL_W{1'b1}};

  logic [LEVEL_W-1:0] lvl_q;
  logic [1:0]         msb_q;
  logic [1:0]         msb_d;
  logic               full_now;
  logic               drain_evt;
  logic               load_rise;
  logic               clk_rise;
  logic               rd_done;
  logic [STAT_W-1:0]  snap;
  logic [FLAG_W-1:0]  rd_clr;
  logic [FLAG_W-1:0]  flags;
  logic [STAT_W-1:0]  snap_masked;

  always_comb begin
    full_now  = cfg_large ? (fill_lvl >= FULL_LARGE) : (fill_lvl >= FULL_SMALL);
    drain_evt = hold_mode && (fill_lvl == '0) && (lvl_q != '0);
    if (cfg_large)               msb_d = fill_lvl[LEVEL_W-1 -: 2];
    else if (fill_lvl > FULL_SMALL) msb_d = 2'b11;
    else                         msb_d = fill_lvl[SMALL_W-1 -: 2];
    snap_masked = snap & {2'b00, RD_CLR_MASK};
    rd_clr      = rd_done ? snap_masked[FLAG_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q     <= '0;
      msb_q     <= '0;
      wr_resume <= 1'b1;
    end else begin
      lvl_q     <= fill_lvl;
      msb_q     <= msb_d;
      wr_resume <= ~(flags[B_EMPTY] & cmd_echo);
    end
  end

  asb_sync_edge #(.STAGES(SYNC_STAGES)) u_load_sync (
    .clk(clk), .rst(rst), .din(ser_load), .rise(load_rise));

  asb_sync_edge #(.STAGES(SYNC_STAGES)) u_clk_sync (
    .clk(clk), .rst(rst), .din(ser_clk), .rise(clk_rise));

  asb_flag_bank u_flags (
    .clk(clk), .rst(rst),
    .sync_evt(sub_sync), .dec_frame(dec_frame), .int_frame(int_frame),
    .full_now(full_now), .drain_evt(drain_evt),
    .dram_wr(dram_wr), .shock(shock),
    .cmd_pfb(cmd_pfb), .cmd_flush(cmd_flush),
    .rd_clr(rd_clr), .flags(flags));

  assign status_word = {msb_q, flags};

  asb_serial_out #(.WIDTH(STAT_W)) u_ser (
    .clk(clk), .rst(rst), .load(load_rise), .shift(clk_rise),
    .par_in(status_word), .ser_data(ser_data), .snap(snap), .done(rd_done));

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flags[B_EMPTY] && cmd_echo) |=> !wr_resume) else $error("wr hold"); // R8
  AST_WR_FREE: assert property (@(posedge clk) disable iff (rst)
    !flags[B_EMPTY] |=> wr_resume) else $error("wr free"); // R8
  AST_FULL_SET: assert property (@(posedge clk) disable iff (rst)
    full_now |=> status_word[B_FULL]) else $error("full"); // R3
  AST_EMPTY_SET: assert property (@(posedge clk) disable iff (rst)
    drain_evt |=> status_word[B_EMPTY]) else $error("empty"); // R7
endmodule

// File: tb/asb_status_ctrl_tb.sv
module asb_status_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_large = 1'b0;
  logic [5:0] fill_lvl = '0;
  logic       sub_sync = 0, dec_frame = 0, int_frame = 0, dram_wr = 0, shock = 0;
  logic       hold_mode = 0, cmd_pfb = 0, cmd_flush = 0, cmd_echo = 0;
  logic       ser_clk = 0, ser_load = 0;
  logic [7:0] status_word;
  logic       ser_data, wr_resume;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asb_status_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_large(cfg_large), .fill_lvl(fill_lvl),
    .sub_sync(sub_sync), .dec_frame(dec_frame), .int_frame(int_frame),
    .dram_wr(dram_wr), .shock(shock), .hold_mode(hold_mode),
    .cmd_pfb(cmd_pfb), .cmd_flush(cmd_flush), .cmd_echo(cmd_echo),
    .ser_clk(ser_clk), .ser_load(ser_load),
    .status_word(status_word), .ser_data(ser_data), .wr_resume(wr_resume));

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0; cyc(3);
  endtask

  task automatic ser_pulse();
    ser_clk = 1'b1; cyc(4); ser_clk = 1'b0; cyc(4);
  endtask

  // full serial read; byte gathered MSB first
  task automatic read_byte(output logic [7:0] b);
    ser_load = 1'b1; cyc(4); ser_load = 1'b0; cyc(4);
    b[7] = ser_data;
    for (int i = 6; i >= 0; i--) begin
      ser_pulse();
      b[i] = ser_data;
    end
    ser_pulse();
    cyc(4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int em, ef;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    check("R1 status", status_word, 0);
    check("R1 ser_data", ser_data, 0);
    check("R1 wr_resume", wr_resume, 1);

    // R2/R3 sweep over every level in both buffer sizes
    for (int c = 0; c < 2; c++) begin
      cfg_large = c[0];
      for (int l = 0; l < 64; l++) begin
        fill_lvl = 6'(l);
        cyc(3);
        em = (c == 1) ? (l >> 4) : ((l > 15) ? 3 : ((l >> 2) & 3));
        ef = (c == 1) ? int'(l == 63) : int'(l >= 15);
        check("R2 level bits", status_word[7:6], em);
        check("R3 full flag", status_word[3], ef);
        fill_lvl = '0;
        cyc(3);
        read_byte(b);
        check("R10 serial byte", b, ef << 3);
        check("R11 full cleared", status_word[3], 0);
      end
    end
    cfg_large = 1'b0;

    // R4/R5 missed frame
    pulse(sub_sync);
    check("R4 new frame", status_word[5:4], 2'b01);
    pulse(sub_sync);
    check("R5 frame error, nsf kept", status_word[5:4], 2'b11);
    read_byte(b);
    check("R10 serial frame byte", b, 8'h30);
    check("R11 frame flags cleared", status_word[5:4], 0);

    // R6 coincidence
    dec_frame = 1; int_frame = 1; cyc(1); dec_frame = 0; int_frame = 0; cyc(3);
    check("R6 coincident frames", status_word[5], 0);
    pulse(dec_frame);
    check("R6 decoder alone", status_word[5], 1);
    read_byte(b);
    pulse(int_frame);
    check("R6 internal alone", status_word[5], 1);
    read_byte(b);
    check("R11 cleared", status_word, 0);

    // R7/R8 drain with echo off
    fill_lvl = 6'd5; cyc(2);
    fill_lvl = 6'd0; cyc(3);
    check("R7 no empty outside hold", status_word[2], 0);
    hold_mode = 1; fill_lvl = 6'd5; cyc(2);
    fill_lvl = 6'd0; cyc(3);
    check("R7 empty on drain", status_word[2], 1);
    check("R8 resume with echo off", wr_resume, 1);
    cmd_echo = 1; cyc(3);
    check("R8 held by echo", wr_resume, 0);
    read_byte(b);
    check("R11 empty not read-cleared", status_word[2], 1);
    pulse(cmd_pfb);
    check("R7 empty cleared by pfb", status_word[2], 0);
    check("R9 fill set by pfb", status_word[0], 1);
    check("R8 resume after pfb", wr_resume, 1);
    fill_lvl = 6'd5; cyc(2);
    fill_lvl = 6'd0; cyc(3);
    check("R8 held again", wr_resume, 0);
    pulse(cmd_flush);
    check("R8 resume after flush", wr_resume, 1);
    cmd_echo = 0;
    fill_lvl = 6'd5; cyc(2);
    fill_lvl = 6'd0; cyc(3);
    pulse(dram_wr);
    check("R7 empty cleared by write", status_word[2], 0);
    hold_mode = 0;

    // R9 fill vs shock
    check("R9 fill before shock", status_word[0], 1);
    pulse(shock);
    check("R9 shock clears fill", status_word[1:0], 2'b10);
    read_byte(b);
    dram_wr = 1; shock = 1; cyc(1); dram_wr = 0; shock = 0; cyc(3);
    check("R9 clear wins", status_word[1:0], 2'b10);
    read_byte(b);
    pulse(dram_wr);
    fill_lvl = 6'd15; cyc(3);
    check("R9 full clears fill", status_word[3] * 2 + status_word[0], 2);
    fill_lvl = 6'd0; cyc(2);
    read_byte(b);
    check("R11 after full read", status_word, 0);

    // R11 snapshot: shock after capture survives
    ser_load = 1'b1; cyc(4); ser_load = 1'b0; cyc(4);
    b[7] = ser_data;
    shock = 1; cyc(1); shock = 0;
    for (int i = 6; i >= 0; i--) begin ser_pulse(); b[i] = ser_data; end
    ser_pulse(); cyc(4);
    check("R11 snapshot bit1 clear", b[1], 0);
    check("R11 late flag kept", status_word[1], 1);
    read_byte(b);
    check("R11 now cleared", status_word[1], 0);

    // R12 set held across the read
    sub_sync = 1; cyc(2);
    read_byte(b);
    check("R12 nsf held", status_word[4], 1);
    sub_sync = 0; cyc(2);
    read_byte(b);
    check("R12 released then cleared", status_word[5:4], 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule